// File: doc/BRIEF.md
# Sense-Reversing Tree Barrier

This block is a hardware rendezvous point for a power-of-two number of participants. Each participant announces that it has reached the barrier with a one-cycle arrive pulse, then waits until the block signals that every participant has arrived.

The arrivals are merged by a binary tree of pair combiners. A combiner forwards a single event upward only once both of its children have reported. Each participant keeps its own sense bit, and the block keeps one shared release bit. A participant is released when these two bits differ. Every completed episode inverts the release bit, so a participant can re-enter the next episode as soon as it is released. Nothing needs to be cleared between episodes.

An arrive pulse from a participant that is already waiting breaks the protocol. The block flags that pulse and otherwise ignores it.

Top module: `tbar_top`

## Requirements
- R1: After reset, release_o is 0, every sense_o bit is 1, every done_o bit is 1 and error_o is all zeros.
- R2: An arrive pulse from a participant whose done_o is 1 inverts that participant's sense_o on the sampling edge, and drives its done_o to 0 from that edge on.
- R3: release_o inverts exactly on the rising edge that comes log2(P) edges after the edge that samples the last outstanding arrival of an episode. It never inverts earlier.
- R4: release_o holds its value while at least one participant has not arrived in the current episode. Arrivals may come in any order, including several in the same cycle, and any number of idle cycles may separate them.
- R5: On the edge where release_o inverts, every done_o bit becomes 1. A done_o bit never rises on any other edge.
- R6: An arrive pulse from a participant whose done_o is 0 sets that participant's error_o bit for one cycle, starting at the sampling edge. It leaves that participant's sense_o unchanged and does not count as an arrival. This also holds for a pulse sent after the last arrival while the release is still travelling up the tree.
- R7: A participant may arrive again in the first cycle after its release. The new episode completes normally, and release_o inverts again, alternating 1, 0, 1, … across episodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| arrive_i | input | P | One-cycle arrive pulse per participant |
| release_o | output | 1 | Shared release sense |
| sense_o | output | P | Local sense bit per participant |
| done_o | output | P | Per-participant released flag (sense differs from release) |
| error_o | output | P | Pulse marking an arrival from a participant that is still waiting |

## Verification
The hardest case to reach is the window between the final arrival and the release flip. In that window every participant is waiting and the tree still holds an event in flight. The stimulus sends a further arrive pulse in the very next cycle after completing an episode, so the pulse lands inside that window and must be rejected without disturbing the flip time. The stimulus also re-enters a new episode with all participants at once in the first cycle after release, which tests that every combiner has cleared itself. Finally, it repeats a pulse from one participant that is already waiting, and holds half of the participants back for many idle cycles.

// File: rtl/tbar_pkg.sv
package tbar_pkg;
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/tbar_leaf.sv
module tbar_leaf (
   input  logic clk,
   input  logic rst_n,
   input  logic arrive_i,
   input  logic release_i,
   output logic sense_o,
   output logic done_o,
   output logic accept_o,
   output logic error_o
);
   logic sense_q;
   logic err_q;

   assign done_o   = (sense_q != release_i);
   assign accept_o = arrive_i & done_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         if (accept_o) sense_q <= ~sense_q;
         err_q <= arrive_i & ~done_o;
      end
   end

   assign sense_o = sense_q;
   assign error_o = err_q;

   // A rejected arrival must not touch the local sense
   assert_err_keeps_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $stable(sense_q));

   // An accepted arrival leaves the participant waiting next cycle
   assert_wait_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !done_o);
endmodule

// File: rtl/tbar_node.sv
module tbar_node (
   input  logic clk,
   input  logic rst_n,
   input  logic left_i,
   input  logic right_i,
   output logic up_o
);
   logic seen_l, seen_r, up_q;
   logic full;

   assign full = (seen_l | left_i) & (seen_r | right_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_l <= 1'b0;
         seen_r <= 1'b0;
         up_q   <= 1'b0;
      end else begin
         up_q   <= full;
         seen_l <= full ? 1'b0 : (seen_l | left_i);
         seen_r <= full ? 1'b0 : (seen_r | right_i);
      end
   end

   assign up_o = up_q;

   // A child may report only once per episode
   assert_no_repeat_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(seen_l && left_i));
   assert_no_repeat_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(seen_r && right_i));
endmodule

// File: rtl/tbar_top.sv
module tbar_top #(
   parameter int P = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [P-1:0] arrive_i,
   output logic         release_o,
   output logic [P-1:0] sense_o,
   output logic [P-1:0] done_o,
   output logic [P-1:0] error_o
);
   import tbar_pkg::*;

   localparam int LEVELS = $clog2(P);
   localparam int NODES  = P - 1;
   localparam int EVW    = 2 * P - 1;

   if (!is_pow2(P) || P < 2) begin : g_bad_p
      $error("tbar_top: P must be a power of two and at least 2");
   end

   logic           release_q;
   logic [P-1:0]   accept;
   logic [EVW-1:0] ev;

   for (genvar p = 0; p < P; p++) begin : g_leaf
      tbar_leaf u_leaf (
         .clk       (clk),
         .rst_n     (rst_n),
         .arrive_i  (arrive_i[p]),
         .release_i (release_q),
         .sense_o   (sense_o[p]),
         .done_o    (done_o[p]),
         .accept_o  (accept[p]),
         .error_o   (error_o[p])
      );
      assign ev[NODES + p] = accept[p];
   end

   for (genvar n = 0; n < NODES; n++) begin : g_node
      tbar_node u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .left_i  (ev[2*n + 1]),
         .right_i (ev[2*n + 2]),
         .up_o    (ev[n])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     release_q <= 1'b0;
      else if (ev[0]) release_q <= ~release_q;
   end

   assign release_o = release_q;

   // Release moves only when the root has combined both halves
   assert_release_only_on_root_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ev[0] |=> $stable(release_q));

   // Every participant is released together with the flip
   assert_all_done_on_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(release_q) |-> (&done_o));

   for (genvar p = 0; p < P; p++) begin : g_chk
      assert_done_rise_on_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done_o[p]) |-> !$stable(release_q));
   end

   if (LEVELS < 1) begin : g_bad_lv
      $error("tbar_top: tree needs at least one level");
   end
endmodule

// File: tb/tbar_top_tb_top.sv
module tbar_top_tb_top;
   localparam int P = 8;
   localparam int L = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [P-1:0] arrive_i = '0;
   logic         release_o;
   logic [P-1:0] sense_o, done_o, error_o;

   tbar_top #(.P(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .arrive_i(arrive_i),
      .release_o(release_o), .sense_o(sense_o), .done_o(done_o), .error_o(error_o)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int cyc; logic val; } item_t;
   item_t sb_q[$];

   logic [P-1:0] m_sense = '1;
   logic [P-1:0] m_arrived = '0;
   logic         m_rel = 1'b0;
   logic         last_rel = 1'b0;
   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one arrive pulse, model update, expected release pushed on completion
   task automatic pulse(input logic [P-1:0] m);
      logic [P-1:0] done_m, ok_m, bad_m;
      for (int i = 0; i < P; i++) done_m[i] = (m_sense[i] != m_rel);
      ok_m  = m & done_m;
      bad_m = m & ~done_m;
      arrive_i = m;
      @(posedge clk);
      @(negedge clk);
      arrive_i = '0;
      m_sense   = m_sense ^ ok_m;
      m_arrived = m_arrived | ok_m;
      chk(sense_o == m_sense, "R2 sense", sense_o, m_sense);
      chk(error_o == bad_m, "R6 error", error_o, bad_m);
      chk((done_o & ok_m) == '0, "R2 done low", done_o, ~ok_m);
      if (m_arrived == '1) begin
         sb_q.push_back('{cyc + L, ~m_rel});
         m_arrived = '0;
      end else begin
         chk(release_o == m_rel, "R4 held", release_o, m_rel);
      end
   endtask

   task automatic wait_release();
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(done_o == '1, "R5 all done", done_o, '1);
   endtask

   // Monitor: pops expected flips and compares edge and value
   always @(negedge clk) begin : mon
      item_t it;
      if (rst_n && (release_o !== last_rel)) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R4 unexpected flip", release_o, last_rel);
         end else begin
            it = sb_q.pop_front();
            chk(cyc == it.cyc, "R3 latency", cyc, it.cyc);
            chk(release_o == it.val, "R7 value", release_o, it.val);
            m_rel = it.val;
         end
         last_rel = release_o;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(release_o == 1'b0, "R1 release", release_o, 0);
      chk(done_o == '1, "R1 done", done_o, '1);
      chk(sense_o == '1, "R1 sense", sense_o, '1);
      chk(error_o == '0, "R1 error", error_o, 0);

      // Episode 1: one at a time with gaps (R4, R3)
      for (int i = 0; i < P; i++) begin
         pulse(P'(1) << i);
         if (i % 2 == 0) @(negedge clk);
      end
      wait_release();

      // Episode 2: repeated arrival while waiting (R6), long hold (R4)
      pulse(8'h08);
      pulse(8'h08);
      pulse(8'h0F);
      repeat (10) @(negedge clk);
      chk(release_o == m_rel, "R4 half held", release_o, m_rel);
      pulse(8'hF0);
      pulse(8'h01);   // lands while the release is in flight (R6)
      wait_release();

      // Episode 3: immediate reuse, all at once (R7)
      pulse(8'hFF);
      wait_release();

      // Episode 4: pairs in reverse order (R4, R7)
      pulse(8'hC0);
      pulse(8'h30);
      pulse(8'h0C);
      pulse(8'h03);
      wait_release();
      chk(release_o == 1'b0, "R7 fourth episode", release_o, 0);

      chk(sb_q.size() == 0, "R3 pending flips", sb_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule